// File: doc/BRIEF.md
# Floating-Point Compare and Min/Max Unit

This unit takes two floating-point operands, either both binary32 or both binary64, and performs one of five operations selected per cycle. Three are ordered compares (equal, greater-than, greater-or-equal) that yield a one-bit predicate. Two are selections (minimum, maximum) that yield a value. Each operation also yields an exception-flag update. That update is ORed into a sticky status word, which is cleared only when `status_clr` is asserted.

A binary32 operand sits in the low 32 bits of its 64-bit input port. The upper 32 bits are ignored. A binary32 result is returned zero-extended. All outputs are registered, so a request presented with `op_valid` is answered one clock later under `res_valid`. NaN handling is the main part of the unit. Compares with any NaN operand are false and raise no flag. Min/max passes the non-NaN operand through when only one input is a NaN, and returns an all-ones canonical NaN when both are. Only the binary64 min/max path reports a signalling NaN as invalid.

Top module: `fpcm_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid`, `pred`, `result`, `flag_set` and `status` are all cleared to zero.
- R2: An operation presented with `op_valid` high at a clock edge appears on `pred`, `result` and `flag_set` with `res_valid` high after that edge. With `op_valid` low, `res_valid` and `flag_set` go to zero, `pred` and `result` hold, and `status` is unchanged.
- R3: `op_sel` codes 0, 1 and 2 select equal, greater-than and greater-or-equal of `opa` against `opb`. For non-NaN operands, +0 equals -0. A positive value is above a negative one. Between negatives, the larger magnitude is the smaller value. `result` is zero for compares.
- R4: Every compare with a NaN operand (exponent all ones, mantissa non-zero), quiet or signalling, gives `pred` = 0 and `flag_set` = 0.
- R5: `op_sel` codes 3 and 4 select minimum and maximum of two non-NaN operands. On a +0/-0 tie, minimum returns -0 and maximum returns +0. `pred` is zero for min/max.
- R6: When exactly one min/max operand is a NaN, the result is the other operand unchanged.
- R7: When both min/max operands are NaN, the result is all ones: 0x00000000FFFFFFFF for binary32 and 0xFFFFFFFFFFFFFFFF for binary64.
- R8: In binary64 min/max, a signalling NaN operand (quiet bit 51 clear) sets the invalid flag, which is bit 1 of `flag_set`. A quiet NaN (bit 51 set) sets no flag. No other flag bit is ever set.
- R9: Binary32 min/max never sets a flag, even for signalling NaNs (quiet bit 22 clear).
- R10: `status` bits stay set until a cycle with `status_clr` high. That cycle clears the word and then ORs in that cycle's own flag update.
- R11: In binary32 mode the upper 32 bits of `opa`/`opb` have no effect and the result's upper 32 bits are zero. `op_sel` codes 5 to 7 return `pred` = 0, `result` = 0 and `flag_set` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation: 0 eq, 1 gt, 2 ge, 3 min, 4 max |
| prec_dbl | input | 1 | 1 = binary64, 0 = binary32 in low half |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| status_clr | input | 1 | Clears the sticky status word |
| res_valid | output | 1 | Result registers hold a fresh answer |
| pred | output | 1 | Compare outcome |
| result | output | 64 | Min/max value |
| flag_set | output | 6 | Flag update of the last operation (bit 1 invalid) |
| status | output | 6 | Sticky accumulated flags |

## Verification
The operand patterns are chosen to separate sign handling from magnitude handling. They include pairs of positive values, pairs of negative values, mixed signs and the two signed zeros, so that a plain unsigned compare or a missing negative reversal produces a wrong predicate. NaN cases vary three things independently: quiet versus signalling, one versus both operands, and binary32 versus binary64. This separates pass-through, canonical return and invalid reporting. Upper-half garbage in binary32 mode and unused opcodes show that the ignored inputs really are ignored. Directed sequences of clearing and setting cover the sticky status word.

// File: rtl/fpcm_pkg.sv
package fpcm_pkg;

    localparam int DW       = 64;
    localparam int SW       = 32;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int MAG_W    = DW - 1;
    localparam int FLG_W    = 6;
    localparam int OP_W     = 3;

    localparam int FLG_INV  = 1;
    localparam int FLG_DBZ  = 2;
    localparam int FLG_OVF  = 3;
    localparam int FLG_UNF  = 4;
    localparam int FLG_INX  = 5;

    typedef enum logic [OP_W-1:0] {
        OP_EQ  = 3'd0,
        OP_GT  = 3'd1,
        OP_GE  = 3'd2,
        OP_MIN = 3'd3,
        OP_MAX = 3'd4
    } fpcm_op_e;

    typedef struct packed {
        logic             sign;
        logic             zero;
        logic             nan;
        logic             snan;
        logic [MAG_W-1:0] mag;
    } fpcm_class_t;

    typedef struct packed {
        logic             pred;
        logic [DW-1:0]    value;
        logic [FLG_W-1:0] flags;
    } fpcm_out_t;

    function automatic logic [DW-1:0] canon_nan(input logic dbl);
        return dbl ? {DW{1'b1}} : {{(DW-SW){1'b0}}, {SW{1'b1}}};
    endfunction

    function automatic logic [DW-1:0] fit_width(input logic [DW-1:0] v, input logic dbl);
        return dbl ? v : {{(DW-SW){1'b0}}, v[SW-1:0]};
    endfunction

endpackage

// File: rtl/fpcm_classify.sv
module fpcm_classify
    import fpcm_pkg::*;
(
    input  logic [DW-1:0] val,
    input  logic          dbl,
    output fpcm_class_t   cls
);
    logic [DP_EXP_W-1:0] d_exp;
    logic [DP_MAN_W-1:0] d_man;
    logic [SP_EXP_W-1:0] s_exp;
    logic [SP_MAN_W-1:0] s_man;

    assign d_exp = val[DW-2 -: DP_EXP_W];
    assign d_man = val[DP_MAN_W-1:0];
    assign s_exp = val[SW-2 -: SP_EXP_W];
    assign s_man = val[SP_MAN_W-1:0];

    always_comb begin
        if (dbl) begin
            cls.sign = val[DW-1];
            cls.mag  = val[MAG_W-1:0];
            cls.nan  = (&d_exp) && (|d_man);
            cls.snan = cls.nan && !d_man[DP_MAN_W-1];
        end else begin
            cls.sign = val[SW-1];
            cls.mag  = {{(MAG_W-SW+1){1'b0}}, val[SW-2:0]};
            cls.nan  = (&s_exp) && (|s_man);
            cls.snan = cls.nan && !s_man[SP_MAN_W-1];
        end
        cls.zero = (cls.mag == '0);
    end
endmodule

// File: rtl/fpcm_order.sv
module fpcm_order
    import fpcm_pkg::*;
(
    input  fpcm_class_t ca,
    input  fpcm_class_t cb,
    output logic        a_eq,
    output logic        a_gt,
    output logic        a_lt
);
    logic both_zero;
    logic mag_gt;
    logic mag_lt;

    assign both_zero = ca.zero && cb.zero;
    assign mag_gt    = ca.mag > cb.mag;
    assign mag_lt    = ca.mag < cb.mag;

    always_comb begin
        a_eq = both_zero || ((ca.sign == cb.sign) && (ca.mag == cb.mag));
        if (both_zero) begin
            a_gt = 1'b0;
            a_lt = 1'b0;
        end else if (ca.sign != cb.sign) begin
            a_gt = !ca.sign;
            a_lt = ca.sign;
        end else if (!ca.sign) begin
            a_gt = mag_gt;
            a_lt = mag_lt;
        end else begin
            a_gt = mag_lt;
            a_lt = mag_gt;
        end
    end
endmodule

// File: rtl/fpcm_pick.sv
module fpcm_pick
    import fpcm_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            dbl,
    input  logic [DW-1:0]   va,
    input  logic [DW-1:0]   vb,
    input  fpcm_class_t     ca,
    input  fpcm_class_t     cb,
    input  logic            a_eq,
    input  logic            a_gt,
    input  logic            a_lt,
    output fpcm_out_t       out
);
    logic          any_nan;
    logic          all_nan;
    logic          inv;
    logic [DW-1:0] fa;
    logic [DW-1:0] fb;
    logic          take_a_min;
    logic          take_a_max;

    assign any_nan    = ca.nan || cb.nan;
    assign all_nan    = ca.nan && cb.nan;
    assign inv        = dbl && (ca.snan || cb.snan);
    assign fa         = fit_width(va, dbl);
    assign fb         = fit_width(vb, dbl);
    assign take_a_min = a_lt || (a_eq && ca.sign);
    assign take_a_max = a_gt || (a_eq && !ca.sign);

    always_comb begin
        out = '0;
        case (fpcm_op_e'(op))
            OP_EQ: out.pred = !any_nan && a_eq;
            OP_GT: out.pred = !any_nan && a_gt;
            OP_GE: out.pred = !any_nan && (a_gt || a_eq);
            OP_MIN, OP_MAX: begin
                out.flags[FLG_INV] = inv;
                if (all_nan)      out.value = canon_nan(dbl);
                else if (ca.nan)  out.value = fb;
                else if (cb.nan)  out.value = fa;
                else if (fpcm_op_e'(op) == OP_MIN)
                    out.value = take_a_min ? fa : fb;
                else
                    out.value = take_a_max ? fa : fb;
            end
            default: out = '0;
        endcase
    end
endmodule

// File: rtl/fpcm_unit.sv
module fpcm_unit
    import fpcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_sel,
    input  logic             prec_dbl,
    input  logic [DW-1:0]    opa,
    input  logic [DW-1:0]    opb,
    input  logic             status_clr,
    output logic             res_valid,
    output logic             pred,
    output logic [DW-1:0]    result,
    output logic [FLG_W-1:0] flag_set,
    output logic [FLG_W-1:0] status
);
    logic [1:0][DW-1:0] opnd;
    fpcm_class_t        cls [2];
    logic               a_eq, a_gt, a_lt;
    fpcm_out_t          nxt;

    assign opnd[0] = opa;
    assign opnd[1] = opb;

    generate
        for (genvar k = 0; k < 2; k++) begin : g_cls
            fpcm_classify i_cls (
                .val (opnd[k]),
                .dbl (prec_dbl),
                .cls (cls[k])
            );
        end
    endgenerate

    fpcm_order i_order (
        .ca   (cls[0]),
        .cb   (cls[1]),
        .a_eq (a_eq),
        .a_gt (a_gt),
        .a_lt (a_lt)
    );

    fpcm_pick i_pick (
        .op   (op_sel),
        .dbl  (prec_dbl),
        .va   (opa),
        .vb   (opb),
        .ca   (cls[0]),
        .cb   (cls[1]),
        .a_eq (a_eq),
        .a_gt (a_gt),
        .a_lt (a_lt),
        .out  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            pred      <= 1'b0;
            result    <= '0;
            flag_set  <= '0;
            status    <= '0;
        end else begin
            res_valid <= op_valid;
            flag_set  <= op_valid ? nxt.flags : '0;
            if (op_valid) begin
                pred   <= nxt.pred;
                result <= nxt.value;
            end
            status <= (status_clr ? '0 : status) | (op_valid ? nxt.flags : '0);
        end
    end
endmodule

// File: rtl/fpcm_unit_chk.sv
module fpcm_unit_chk
    import fpcm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [OP_W-1:0]  op_sel,
    input logic             prec_dbl,
    input logic             status_clr,
    input logic             res_valid,
    input logic             pred,
    input logic [DW-1:0]    result,
    input logic [FLG_W-1:0] flag_set,
    input logic [FLG_W-1:0] status
);
    AST_ONE_CYCLE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        ($past(op_valid) && !$past(rst)) |-> res_valid); // R2

    AST_COMPARE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(op_sel) <= 3'd2) |-> (flag_set == '0)); // R4

    AST_INVALID_ONLY_DBL: assert property (@(posedge clk) disable iff (rst)
        flag_set[FLG_INV] |-> (res_valid && $past(prec_dbl))); // R8

    AST_SINGLE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !$past(prec_dbl)) |-> (flag_set == '0)); // R9

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(status_clr) |-> ((status & $past(status)) == $past(status))); // R10

    AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !$past(prec_dbl)) |-> (result[DW-1:SW] == '0)); // R11

    AST_SELECT_NO_PRED: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(op_sel) >= 3'd3) |-> !pred); // R5
endmodule

bind fpcm_unit fpcm_unit_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_sel     (op_sel),
    .prec_dbl   (prec_dbl),
    .status_clr (status_clr),
    .res_valid  (res_valid),
    .pred       (pred),
    .result     (result),
    .flag_set   (flag_set),
    .status     (status)
);

// File: tb/test_fpcm_unit.sv
`timescale 1ns/1ps
module test_fpcm_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_sel;
    logic        prec_dbl;
    logic [63:0] opa, opb;
    logic        status_clr;
    logic        res_valid, pred;
    logic [63:0] result;
    logic [5:0]  flag_set, status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    fpcm_unit i_fpcm_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .prec_dbl(prec_dbl), .opa(opa), .opb(opb), .status_clr(status_clr),
        .res_valid(res_valid), .pred(pred), .result(result),
        .flag_set(flag_set), .status(status)
    );

    localparam logic [63:0] S1  = 64'h3f800000, S2 = 64'h40000000;
    localparam logic [63:0] SN1 = 64'hbf800000, SN2 = 64'hc0000000;
    localparam logic [63:0] SPZ = 64'h0, SNZ = 64'h80000000;
    localparam logic [63:0] SQN = 64'h7fc00000, SSN = 64'h7f800001;
    localparam logic [63:0] D1  = 64'h3ff0000000000000, D2 = 64'h4000000000000000;
    localparam logic [63:0] DN1 = 64'hbff0000000000000, DN2 = 64'hc000000000000000;
    localparam logic [63:0] DQN = 64'h7ff8000000000000, DSN = 64'h7ff7000000000000;
    localparam logic [63:0] ONES = 64'hffffffffffffffff, SONES = 64'h00000000ffffffff;

    typedef struct packed {
        logic [2:0]  op;
        logic        dbl;
        logic [63:0] a;
        logic [63:0] b;
        logic        pred;
        logic [63:0] res;
        logic [5:0]  flg;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, S1,  S1,  1'b1, 64'h0, 6'h0, 4'd3},   // R3 eq
        '{3'd1, 1'b0, S2,  S1,  1'b1, 64'h0, 6'h0, 4'd3},   // R3 gt
        '{3'd1, 1'b0, S1,  S2,  1'b0, 64'h0, 6'h0, 4'd3},   // R3 gt false
        '{3'd2, 1'b0, S1,  S1,  1'b1, 64'h0, 6'h0, 4'd3},   // R3 ge equal
        '{3'd1, 1'b0, SN1, SN2, 1'b1, 64'h0, 6'h0, 4'd3},   // R3 negatives reversed
        '{3'd0, 1'b0, SPZ, SNZ, 1'b1, 64'h0, 6'h0, 4'd3},   // R3 +0 == -0
        '{3'd1, 1'b0, SPZ, SNZ, 1'b0, 64'h0, 6'h0, 4'd3},   // R3 +0 not > -0
        '{3'd1, 1'b1, D2,  DN1, 1'b1, 64'h0, 6'h0, 4'd3},   // R3 mixed sign
        '{3'd0, 1'b0, SQN, SQN, 1'b0, 64'h0, 6'h0, 4'd4},   // R4
        '{3'd2, 1'b1, DQN, D1,  1'b0, 64'h0, 6'h0, 4'd4},   // R4
        '{3'd1, 1'b1, DSN, D1,  1'b0, 64'h0, 6'h0, 4'd4},   // R4 signalling quiet
        '{3'd2, 1'b0, S1,  SQN, 1'b0, 64'h0, 6'h0, 4'd4},   // R4
        '{3'd3, 1'b0, S1,  S2,  1'b0, S1,    6'h0, 4'd5},   // R5 min
        '{3'd4, 1'b0, S1,  S2,  1'b0, S2,    6'h0, 4'd5},   // R5 max
        '{3'd3, 1'b1, DN1, D2,  1'b0, DN1,   6'h0, 4'd5},   // R5
        '{3'd4, 1'b1, DN1, DN2, 1'b0, DN1,   6'h0, 4'd5},   // R5 negatives
        '{3'd3, 1'b0, SPZ, SNZ, 1'b0, SNZ,   6'h0, 4'd5},   // R5 zero tie min
        '{3'd4, 1'b0, SNZ, SPZ, 1'b0, SPZ,   6'h0, 4'd5},   // R5 zero tie max
        '{3'd3, 1'b0, SQN, S1,  1'b0, S1,    6'h0, 4'd6},   // R6
        '{3'd4, 1'b0, S1,  SQN, 1'b0, S1,    6'h0, 4'd6},   // R6
        '{3'd3, 1'b1, DQN, D1,  1'b0, D1,    6'h0, 4'd8},   // R8 quiet no flag
        '{3'd4, 1'b1, DSN, D1,  1'b0, D1,    6'h2, 4'd8},   // R8 invalid
        '{3'd3, 1'b1, D2,  DSN, 1'b0, D2,    6'h2, 4'd8},   // R8
        '{3'd3, 1'b0, SQN, SQN, 1'b0, SONES, 6'h0, 4'd7},   // R7 single
        '{3'd4, 1'b1, DQN, DQN, 1'b0, ONES,  6'h0, 4'd7},   // R7 double
        '{3'd3, 1'b1, DSN, DSN, 1'b0, ONES,  6'h2, 4'd7},   // R7 with invalid
        '{3'd4, 1'b0, SSN, S1,  1'b0, S1,    6'h0, 4'd9},   // R9
        '{3'd3, 1'b0, SSN, SSN, 1'b0, SONES, 6'h0, 4'd9},   // R9
        '{3'd0, 1'b0, 64'hdeadbeef3f800000, 64'h123456783f800000, 1'b1, 64'h0, 6'h0, 4'd11}, // R11
        '{3'd4, 1'b0, 64'hffffffff3f800000, S2, 1'b0, S2, 6'h0, 4'd11},                     // R11
        '{3'd5, 1'b1, D1,  D1,  1'b0, 64'h0, 6'h0, 4'd11}   // R11 unused code
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_valid = 1'b1; op_sel = 3'd4; prec_dbl = 1'b1;
        opa = DSN; opb = D1; status_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state even with a request pending
        chk(res_valid == 0 && pred == 0 && flag_set == 0, "R1 flags/valid", {58'b0, flag_set}, 64'h0);
        chk(result == 0, "R1 result", result, 64'h0);
        chk(status == 0, "R1 status", {58'b0, status}, 64'h0);
        op_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel = VECS[i].op; prec_dbl = VECS[i].dbl;
            opa = VECS[i].a; opb = VECS[i].b; op_valid = 1'b1;
            @(negedge clk);
            op_valid = 1'b0;
            chk(res_valid == 1'b1, $sformatf("R2 valid vec %0d", i), {63'b0, res_valid}, 64'h1);
            chk(pred == VECS[i].pred, $sformatf("R%0d pred vec %0d", VECS[i].req, i), {63'b0, pred}, {63'b0, VECS[i].pred});
            chk(result == VECS[i].res, $sformatf("R%0d result vec %0d", VECS[i].req, i), result, VECS[i].res);
            chk(flag_set == VECS[i].flg, $sformatf("R%0d flags vec %0d", VECS[i].req, i), {58'b0, flag_set}, {58'b0, VECS[i].flg});
        end

        // R10: invalid from earlier vectors is still held
        chk(status == 6'h2, "R10 sticky", {58'b0, status}, 64'h2);
        // R2: idle cycle leaves status, drops valid and flag_set, holds result
        @(negedge clk);
        chk(res_valid == 0 && flag_set == 0, "R2 idle", {58'b0, flag_set}, 64'h0);
        chk(status == 6'h2, "R2 idle status", {58'b0, status}, 64'h2);
        chk(result == 64'h0 && pred == 0, "R2 hold", result, 64'h0);
        // R10: clear
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        chk(status == 6'h0, "R10 clear", {58'b0, status}, 64'h0);
        // R10: clear together with a new invalid update keeps the new one
        op_valid = 1'b1; op_sel = 3'd3; prec_dbl = 1'b1; opa = DSN; opb = D2; status_clr = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; status_clr = 1'b0;
        chk(status == 6'h2, "R10 clear+set", {58'b0, status}, 64'h2);
        chk(result == D2, "R6 double pass-through", result, D2);
        // R9: single signalling NaN does not add to a cleared status
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        op_valid = 1'b1; op_sel = 3'd4; prec_dbl = 1'b0; opa = SSN; opb = SSN;
        @(negedge clk);
        op_valid = 1'b0;
        chk(status == 6'h0, "R9 status untouched", {58'b0, status}, 64'h0);
        // R1: reset mid-run clears results
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(res_valid == 0 && result == 0, "R1 mid-run reset", result, 64'h0);

        done = 1;
        summary();
        $finish;
    end
endmodule